// File: doc/BRIEF.md
# Double-Buffered Synaptic Weight Accumulator

This block gathers synaptic weights addressed to target potentials during one simulation time slice and delivers their per-target sums during the following slice. It keeps two complete, uncompressed accumulator banks. Each bank entry holds a signed sum and a tag bit that marks the entry as holding a live value. In any slice one bank is the receiver and the other is the sender. The receiver takes (index, weight) pairs from an upstream connection lookup and updates the addressed entry in place with a read-accumulate-write. The sender walks its entries in ascending index order and emits only the tagged ones. It clears each entry as that entry leaves.

The sums are ready one slice before they are used. Downstream decay, propagation and threshold work can therefore run alongside accumulation. Many spikes that reach the same target inside a slice leave the block as a single sum.

A slice strobe asks the banks to swap roles. The swap waits until the sender has finished its walk and no receive update is still in the pipeline. While it waits, a stall output is high and the request is held.

Top module: `wacc_pingpong`

## Requirements
- R1: Bank A is the receiver after reset. Each swap exchanges the roles of the two banks, and the sender of a slice emits exactly what the receiver collected in the slice before the swap.
- R2: A receive at an untagged entry stores the sign-extended 8-bit weight and sets the tag. A receive at a tagged entry adds the weight to the stored 16-bit sum.
- R3: Sums saturate at +32767 and -32768 instead of wrapping. A later weight of opposite sign moves the sum away from the saturated limit.
- R4: Receives to the same index on consecutive cycles are all counted. No update is lost to the read-accumulate-write latency.
- R5: The sender emits only tagged entries, in ascending index order. Each emitted entry carries its index, its sum, and tx_tag_o = 1.
- R6: An emitted entry is cleared, value and tag. When the bank next becomes receiver it starts empty, so weights from earlier slices never reappear.
- R7: An entry is consumed only on a cycle with tx_valid_o and tx_ready_i both high. While tx_valid_o is high and tx_ready_i is low, the index and value hold steady.
- R8: A swap takes place only at a clock edge where a request is present (slice_i high or an earlier request held), the sender walk is finished, and no receive update is pending. Otherwise stall_o is high and the request is retained until the swap occurs.
- R9: After reset both banks are empty, tx_valid_o is 0 and stall_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slice_i | input | 1 | Time-slice strobe, requests a bank swap |
| stall_o | output | 1 | Swap requested but not yet possible |
| rx_valid_i | input | 1 | Receive pair valid |
| rx_idx_i | input | IDX_W | Target entry index |
| rx_weight_i | input | W_W | Signed weight |
| tx_valid_o | output | 1 | Sender entry valid |
| tx_ready_i | input | 1 | Downstream accepts sender entry |
| tx_idx_o | output | IDX_W | Index of emitted entry |
| tx_value_o | output | ACC_W | Signed accumulated sum |
| tx_tag_o | output | 1 | Tag of emitted entry |

## Verification
The bench builds the block with IDX_W = 3, which gives eight entries per bank. Every slice therefore touches each location of the sender walk, and repeated streams of random pairs reach all indices in both banks through several role swaps. With weights of 127 and -128, a few hundred receives drive a sum to either saturation limit. The bench also exercises same-index back-to-back receives, backpressure on the sender, and swap requests made while a walk is still running, checking each against a slice-by-slice arithmetic model.

// File: rtl/wacc_pkg.sv
package wacc_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/wacc_bank.sv
module wacc_bank #(
  parameter int IDX_W = 4,
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ACC_W-1:0] wr_val_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ACC_W-1:0] rd_val_o,
  output logic             rd_tag_o,
  input  logic [IDX_W-1:0] sc_idx_i,
  output logic [ACC_W-1:0] sc_val_o,
  output logic             sc_tag_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ACC_W-1:0] val_q [DEPTH];
  logic [DEPTH-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) val_q[i] <= '0;
      tag_q <= '0;
    end else begin
      if (wr_en_i) begin
        val_q[wr_idx_i] <= wr_val_i;
        tag_q[wr_idx_i] <= 1'b1;
      end
      // write and clear never target one bank in the same cycle
      if (clr_en_i) begin
        val_q[clr_idx_i] <= '0;
        tag_q[clr_idx_i] <= 1'b0;
      end
    end
  end

  assign rd_val_o = val_q[rd_idx_i];
  assign rd_tag_o = tag_q[rd_idx_i];
  assign sc_val_o = val_q[sc_idx_i];
  assign sc_tag_o = tag_q[sc_idx_i];
endmodule

// File: rtl/wacc_rmw.sv
module wacc_rmw
  import wacc_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int W_W   = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IDX_W-1:0] in_idx_i,
  input  logic [W_W-1:0]   in_w_i,
  input  bank_e            in_bank_i,
  input  logic [ACC_W-1:0] rd_val_i,
  input  logic             rd_tag_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [ACC_W-1:0] wr_val_o,
  output bank_e            wr_bank_o,
  output logic             busy_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic             p_valid_q;
  logic [IDX_W-1:0] p_idx_q;
  logic [W_W-1:0]   p_w_q;
  bank_e            p_bank_q;
  logic [ACC_W-1:0] p_old_q;
  logic             p_tag_q;

  logic signed [ACC_W:0]   sum_ext;
  logic        [ACC_W-1:0] sum_sat;
  logic        [ACC_W-1:0] w_ext;
  logic        [ACC_W-1:0] new_val;
  logic                    fwd;

  always_comb begin
    w_ext   = ACC_W'($signed(p_w_q));
    sum_ext = $signed({p_old_q[ACC_W-1], p_old_q}) + $signed({w_ext[ACC_W-1], w_ext});
    if (sum_ext[ACC_W] != sum_ext[ACC_W-1])
      sum_sat = sum_ext[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      sum_sat = sum_ext[ACC_W-1:0];
    new_val = p_tag_q ? sum_sat : w_ext;
  end

  // update in flight to the same entry: bank read is stale, take the pending sum
  assign fwd = in_valid_i && p_valid_q && (in_idx_i == p_idx_q) && (in_bank_i == p_bank_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid_q <= 1'b0;
      p_idx_q   <= '0;
      p_w_q     <= '0;
      p_bank_q  <= BANK_A;
      p_old_q   <= '0;
      p_tag_q   <= 1'b0;
    end else begin
      p_valid_q <= in_valid_i;
      if (in_valid_i) begin
        p_idx_q  <= in_idx_i;
        p_w_q    <= in_w_i;
        p_bank_q <= in_bank_i;
        p_old_q  <= fwd ? new_val : rd_val_i;
        p_tag_q  <= fwd ? 1'b1 : rd_tag_i;
      end
    end
  end

  assign wr_en_o   = p_valid_q;
  assign wr_idx_o  = p_idx_q;
  assign wr_val_o  = new_val;
  assign wr_bank_o = p_bank_q;
  assign busy_o    = p_valid_q;
endmodule

// File: rtl/wacc_scan.sv
module wacc_scan #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tag_i,
  input  logic             ready_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             done_o,
  output logic             emit_o,
  output logic             take_o
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  logic [IDX_W-1:0] ptr_q;
  logic             done_q;
  logic             adv;

  assign emit_o = !done_q && tag_i;
  assign take_o = emit_o && ready_i;
  assign adv    = !done_q && (!tag_i || ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      done_q <= 1'b1;
    end else if (start_i) begin
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else if (adv) begin
      if (ptr_q == LAST) done_q <= 1'b1;
      else               ptr_q  <= ptr_q + 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign done_o = done_q;
endmodule

// File: rtl/wacc_pingpong.sv
module wacc_pingpong
  import wacc_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int W_W   = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slice_i,
  output logic             stall_o,
  input  logic             rx_valid_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  input  logic [W_W-1:0]   rx_weight_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [IDX_W-1:0] tx_idx_o,
  output logic [ACC_W-1:0] tx_value_o,
  output logic             tx_tag_o
);
  localparam int NBANK = 2;

  bank_e            recv_q;
  bank_e            send_sel;
  bank_e            in_bank;
  logic             pend_q;
  logic             req;
  logic             swap;
  logic             scan_done;
  logic             rmw_busy;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [ACC_W-1:0] wr_val;
  bank_e            wr_bank;
  logic [IDX_W-1:0] scan_ptr;
  logic             scan_emit;
  logic             scan_take;

  logic [ACC_W-1:0] rd_val [NBANK];
  logic             rd_tag [NBANK];
  logic [ACC_W-1:0] sc_val [NBANK];
  logic             sc_tag [NBANK];

  assign send_sel = other_bank(recv_q);
  assign req      = slice_i || pend_q;
  assign swap     = req && scan_done && !rmw_busy;
  assign stall_o  = req && !swap;
  // a pair presented on the swap edge belongs to the new slice
  assign in_bank  = swap ? send_sel : recv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recv_q <= BANK_A;
      pend_q <= 1'b0;
    end else begin
      pend_q <= stall_o;
      if (swap) recv_q <= send_sel;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wacc_bank #(.IDX_W(IDX_W), .ACC_W(ACC_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en && (wr_bank == bank_e'(b))),
      .wr_idx_i  (wr_idx),
      .wr_val_i  (wr_val),
      .clr_en_i  (scan_take && (send_sel == bank_e'(b))),
      .clr_idx_i (scan_ptr),
      .rd_idx_i  (rx_idx_i),
      .rd_val_o  (rd_val[b]),
      .rd_tag_o  (rd_tag[b]),
      .sc_idx_i  (scan_ptr),
      .sc_val_o  (sc_val[b]),
      .sc_tag_o  (sc_tag[b])
    );
  end

  wacc_rmw #(.IDX_W(IDX_W), .W_W(W_W), .ACC_W(ACC_W)) u_rmw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (rx_valid_i),
    .in_idx_i   (rx_idx_i),
    .in_w_i     (rx_weight_i),
    .in_bank_i  (in_bank),
    .rd_val_i   (rd_val[in_bank]),
    .rd_tag_i   (rd_tag[in_bank]),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_val_o   (wr_val),
    .wr_bank_o  (wr_bank),
    .busy_o     (rmw_busy)
  );

  wacc_scan #(.IDX_W(IDX_W)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (swap),
    .tag_i   (sc_tag[send_sel]),
    .ready_i (tx_ready_i),
    .ptr_o   (scan_ptr),
    .done_o  (scan_done),
    .emit_o  (scan_emit),
    .take_o  (scan_take)
  );

  assign tx_valid_o = scan_emit;
  assign tx_idx_o   = scan_ptr;
  assign tx_value_o = sc_val[send_sel];
  assign tx_tag_o   = sc_tag[send_sel];
endmodule

// File: rtl/wacc_pingpong_chk.sv
module wacc_pingpong_chk #(
  parameter int IDX_W = 4,
  parameter int ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slice_i,
  input logic             stall_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic [IDX_W-1:0] tx_idx_o,
  input logic [ACC_W-1:0] tx_value_o,
  input logic             tx_tag_o
);
  // R5: emitted entries are always tagged
  a_r5_tag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_tag_o);

  // R5: after a hand-off the next offered index is strictly higher
  a_r5_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) |=> (!tx_valid_o || (tx_idx_o > $past(tx_idx_o))));

  // R7: offered entry holds under backpressure
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_idx_o) && $stable(tx_value_o)));

  // R8: an unfinished walk blocks a swap request
  a_r8_stall_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slice_i && tx_valid_o) |-> stall_o);

  // R8: stall only appears while some request exists
  a_r8_stall_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !slice_i) |-> $past(stall_o));
endmodule

bind wacc_pingpong wacc_pingpong_chk #(.IDX_W(IDX_W), .ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .slice_i    (slice_i),
  .stall_o    (stall_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_idx_o   (tx_idx_o),
  .tx_value_o (tx_value_o),
  .tx_tag_o   (tx_tag_o)
);

// File: tb/wacc_pingpong_tb_top.sv
`timescale 1ns/1ps
module wacc_pingpong_tb_top;
  localparam int IDX_W = 3;
  localparam int W_W   = 8;
  localparam int ACC_W = 16;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             slice = 1'b0;
  logic             stall;
  logic             rx_valid = 1'b0;
  logic [IDX_W-1:0] rx_idx = '0;
  logic [W_W-1:0]   rx_w = '0;
  logic             tx_valid;
  logic             tx_ready = 1'b0;
  logic [IDX_W-1:0] tx_idx;
  logic [ACC_W-1:0] tx_value;
  logic             tx_tag;

  int checks = 0;
  int errors = 0;
  int recv_m [DEPTH];
  bit recv_t [DEPTH];
  int send_m [DEPTH];
  bit send_t [DEPTH];
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  wacc_pingpong #(.IDX_W(IDX_W), .W_W(W_W), .ACC_W(ACC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slice_i(slice), .stall_o(stall),
    .rx_valid_i(rx_valid), .rx_idx_i(rx_idx), .rx_weight_i(rx_w),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_idx_o(tx_idx),
    .tx_value_o(tx_value), .tx_tag_o(tx_tag)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int unsigned lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic rx(int idx, int w);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_idx   = IDX_W'(idx);
    rx_w     = W_W'(w);
    if (recv_t[idx]) recv_m[idx] = sat16(recv_m[idx] + w);
    else begin recv_m[idx] = w; recv_t[idx] = 1'b1; end
  endtask

  task automatic rx_idle();
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // R8: hold the request until stall drops; the swap takes the next edge
  task automatic do_swap(bit expect_stall);
    bit saw;
    @(negedge clk);
    slice = 1'b1;
    #1;
    saw = stall;
    if (expect_stall) check(saw == 1'b1, "R8 stall while blocked", int'(saw), 1);
    while (stall) begin
      @(negedge clk);
      #1;
    end
    for (int i = 0; i < DEPTH; i++) begin
      send_m[i] = recv_m[i]; send_t[i] = recv_t[i];
      recv_m[i] = 0;         recv_t[i] = 1'b0;
    end
    @(negedge clk);
    slice = 1'b0;
  endtask

  task automatic drain(bit bp);
    int exp_n = 0;
    int got_n = 0;
    int nexp = 0;
    bit held = 1'b0;
    int h_idx = 0;
    int h_val = 0;
    for (int i = 0; i < DEPTH; i++) if (send_t[i]) exp_n++;
    for (int c = 0; c < DEPTH * 4 + 10; c++) begin
      @(negedge clk);
      tx_ready = bp ? ((c % 3) != 0) : 1'b1;
      #1;
      if (held) begin
        check(tx_valid && int'(tx_idx) == h_idx && int'($signed(tx_value)) == h_val,
              "R7 hold under backpressure", int'($signed(tx_value)), h_val);
        held = 1'b0;
      end
      if (tx_valid && !tx_ready) begin
        held = 1'b1; h_idx = int'(tx_idx); h_val = int'($signed(tx_value));
      end
      if (tx_valid && tx_ready) begin
        while (nexp < DEPTH && !send_t[nexp]) nexp++;
        check(int'(tx_idx) == nexp, "R1,R5 emitted index order", int'(tx_idx), nexp);
        if (nexp < DEPTH) begin
          check(int'($signed(tx_value)) == send_m[nexp], "R2,R3,R4,R6 emitted sum",
                int'($signed(tx_value)), send_m[nexp]);
          send_t[nexp] = 1'b0;
        end
        check(tx_tag == 1'b1, "R5 tag of emitted entry", int'(tx_tag), 1);
        got_n++;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    check(got_n == exp_n, "R5 emitted entry count", got_n, exp_n);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      recv_m[i] = 0; recv_t[i] = 1'b0; send_m[i] = 0; send_t[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    check(tx_valid == 1'b0, "R9 reset tx_valid", int'(tx_valid), 0);
    check(stall == 1'b0, "R9 reset stall", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(tx_valid == 1'b0, "R9 no output after reset", int'(tx_valid), 0);

    // basic mix, swap right after last pair (R8: pending update stalls one cycle)
    rx(0, 5); rx(3, -7); rx(7, 100); rx(3, 2);
    @(negedge clk); rx_valid = 1'b0;
    slice = 1'b1;
    #1;
    check(stall == 1'b1, "R8 stall on pending update", int'(stall), 1);
    slice = 1'b0;
    do_swap(1'b0);
    drain(1'b0);

    // R4: same index back to back
    for (int k = 0; k < 10; k++) rx(5, 1);
    rx(2, -128); rx(2, -128); rx(5, -3);
    rx_idle();
    do_swap(1'b0);
    drain(1'b1);

    // R6: bank A again, must start empty
    rx(3, 9);
    rx_idle();
    do_swap(1'b0);
    drain(1'b0);

    // R3: saturation at both limits, then recovery
    for (int k = 0; k < 300; k++) rx(1, 127);
    for (int k = 0; k < 300; k++) rx(6, -128);
    rx(1, -1); rx(6, 1);
    rx_idle();
    do_swap(1'b0);
    drain(1'b0);
    check(send_m[1] == 32766 && send_m[6] == -32767, "R3 model limits", send_m[1], 32766);

    // R1 sweep: receive next slice while sending the current one
    for (int k = 0; k < 40; k++) rx(int'(lcg() % DEPTH), int'(lcg() % 256) - 128);
    rx_idle();
    for (int s = 0; s < 8; s++) begin
      do_swap(1'b0);
      fork
        drain(s[0]);
        begin
          for (int k = 0; k < 30; k++) begin
            if ((lcg() % 4) == 0) rx_idle();
            else rx(int'(lcg() % DEPTH), int'(lcg() % 256) - 128);
          end
          rx_idle();
        end
      join
    end

    // empty slice emits nothing
    do_swap(1'b0);
    drain(1'b0);
    do_swap(1'b0);
    drain(1'b0);

    // R8: swap request while the walk is still running
    rx(4, 11); rx(0, -2);
    rx_idle();
    do_swap(1'b0);
    fork
      drain(1'b1);
      do_swap(1'b1);
    join
    drain(1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule